// File: doc/BRIEF.md
# Host Internal-Memory Access Port

This block lets an outside host read and write the processor's on-chip program memory (24-bit words) and data memory (16-bit words) through a narrow 16-bit port. The host has a select line, an address-latch strobe, read and write strobes, a 16-bit data bus and an acknowledge line that reads high when the port is idle. A strobe acts on its rising edge while select is high. The block samples all host lines in the processor clock domain.

A word latched through the address-latch strobe is decoded by its top bit. With bit 15 set, it picks a memory overlay in its low byte. With bit 15 clear, it sets the internal start address and the memory space. Each data strobe after that moves one host word. The internal side is a request/grant memory port that is held for exactly one granted cycle per memory word. The address steps on by one after every memory word. Writes that fall in the data-memory range reserved for control registers are dropped.

Top module: `hostmem_port`

## Requirements
- R1: After reset, h_ack is 1, m_req is 0, ovl_sel is 0, cfg_err is 0 and h_rdata is 0.
- R2: A latched word with bit 15 = 0 sets the address to bits 13:0 and the space to bit 14 (1 = data memory, 0 = program memory). The next data access uses that address and space.
- R3: A latched word with bit 15 = 1 and bits 14:8 all zero loads bits 7:0 into ovl_sel and clears cfg_err. It leaves the address unchanged.
- R4: A latched word with bit 15 = 1 and any of bits 14:8 set raises cfg_err and leaves ovl_sel unchanged.
- R5: In data memory, each host write issues one request with m_wdata = {8'h00, data}. Each host read returns m_rdata[15:0] on h_rdata.
- R6: In program memory, a 24-bit word takes two host words, upper 16 bits first. A write sends {first, second[7:0]} in a single request. A read returns bits 23:8 and then {8'h00, bits 7:0}, and only the first of the two reads makes a request.
- R7: The address increases by one after each granted memory word and wraps from 14'h3FFF to 0.
- R8: From the cycle after a strobe edge that needs memory, m_req is high and h_ack is low. m_req, m_addr, m_wdata and m_we hold steady until m_gnt. h_ack returns high on the cycle after the single grant.
- R9: A data-memory write at an address at or above CTL_BASE makes no request and keeps h_ack high. The address still advances.
- R10: Strobe edges that arrive while a request is pending are ignored.
- R11: Strobes with h_sel low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst_n | input | 1 | active-low reset |
| h_sel | input | 1 | host select |
| h_latch | input | 1 | host address-latch strobe |
| h_rd | input | 1 | host read strobe |
| h_wr | input | 1 | host write strobe |
| h_wdata | input | 16 | host write data / control word |
| h_rdata | output | 16 | host read data |
| h_ack | output | 1 | high when the port is idle |
| ovl_sel | output | 8 | current overlay selection |
| cfg_err | output | 1 | malformed overlay word seen |
| m_req | output | 1 | internal memory request |
| m_gnt | input | 1 | internal memory grant |
| m_we | output | 1 | request is a write |
| m_space | output | 1 | 1 = data memory, 0 = program memory |
| m_addr | output | 14 | internal word address |
| m_wdata | output | 24 | internal write data |
| m_rdata | input | 24 | internal read data, valid with m_gnt |

## Verification
The main function is tried with data-memory word streams, with two-part program-memory streams, and with overlay words mixed into address words. The data-memory streams separate correct address stepping from reuse of a single location. The program-memory streams show whether the upper and lower halves are ordered correctly and whether only one request goes out per 24-bit word. The mixed streams show that overlay words leave the address alone. Grant delays of zero to two cycles are used so that held requests and the length of the acknowledge-low window can be told apart from immediate grants. Directed cases cover a write into the control range, strobes while busy, strobes without select, and address wrap.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  localparam int HW = 16;  // host word
  localparam int PW = 24;  // program-memory word
  localparam int AW = 14;  // internal address
  localparam int OW = 8;   // overlay field / low byte

  typedef enum logic [1:0] {EV_NONE, EV_LATCH, EV_RD, EV_WR} hev_e;

  function automatic logic cw_is_ovl(input logic [HW-1:0] w);
    return w[HW-1];
  endfunction

  function automatic logic cw_ovl_ok(input logic [HW-1:0] w);
    return w[HW-2:OW] == '0;
  endfunction

  function automatic logic [AW-1:0] cw_addr(input logic [HW-1:0] w);
    return w[AW-1:0];
  endfunction

  function automatic logic cw_dm(input logic [HW-1:0] w);
    return w[AW];
  endfunction

  function automatic logic [PW-1:0] pm_join(input logic [HW-1:0] hi, input logic [HW-1:0] lo);
    return {hi, lo[PW-HW-1:0]};
  endfunction

  function automatic logic [HW-1:0] low_word(input logic [OW-1:0] b);
    return {{(HW-OW){1'b0}}, b};
  endfunction

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic in_ctl(input logic dm, input logic [AW-1:0] a, input logic [AW-1:0] base);
    return dm && (a >= base);
  endfunction
endpackage

// File: rtl/hmp_strobe.sv
module hmp_strobe
  import hmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic lat,
  input  logic wr,
  input  logic rd,
  input  logic busy,
  output hev_e ev,
  output logic ev_drop
);
  localparam int NS = 3;
  logic [NS-1:0] cur, prev_q, rise;
  hev_e raw;

  assign cur  = {sel & lat, sel & wr, sel & rd};
  assign rise = cur & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  always_comb begin
    if (rise[2])      raw = EV_LATCH;
    else if (rise[1]) raw = EV_WR;
    else if (rise[0]) raw = EV_RD;
    else              raw = EV_NONE;
  end

  assign ev      = busy ? EV_NONE : raw;
  assign ev_drop = busy && (raw != EV_NONE);

  // R11: no event without select
  a_r11_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> ev == EV_NONE);
endmodule

// File: rtl/hmp_ctl.sv
module hmp_ctl
  import hmp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  hev_e          ev,
  input  logic [HW-1:0] wdata,
  output logic [OW-1:0] ovl,
  output logic          err,
  output logic          ld,
  output logic [AW-1:0] ld_addr,
  output logic          ld_dm
);
  logic ovl_hit, ovl_bad;

  assign ovl_hit = (ev == EV_LATCH) && cw_is_ovl(wdata);
  assign ovl_bad = ovl_hit && !cw_ovl_ok(wdata);
  assign ld      = (ev == EV_LATCH) && !cw_is_ovl(wdata);
  assign ld_addr = cw_addr(wdata);
  assign ld_dm   = cw_dm(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl <= '0;
      err <= 1'b0;
    end else if (ovl_hit) begin
      if (ovl_bad) err <= 1'b1;
      else begin
        ovl <= wdata[OW-1:0];
        err <= 1'b0;
      end
    end
  end

  // R3: well-formed overlay word lands in the overlay register
  a_r3_ovl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_hit && !ovl_bad) |=> (ovl == $past(wdata[OW-1:0]) && !err));
  // R4: malformed overlay word keeps the old overlay and flags
  a_r4_ovl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_bad |=> ($stable(ovl) && err));
endmodule

// File: rtl/hmp_xfer.sv
module hmp_xfer
  import hmp_pkg::*;
#(
  parameter logic [AW-1:0] CTL_BASE = 14'h3FE0
)(
  input  logic          clk,
  input  logic          rst_n,
  input  hev_e          ev,
  input  logic          ev_drop,
  input  logic [HW-1:0] wdata,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_dm,
  input  logic          m_gnt,
  input  logic [PW-1:0] m_rdata,
  output logic          busy,
  output logic          m_req,
  output logic          m_we,
  output logic          m_space,
  output logic [AW-1:0] m_addr,
  output logic [PW-1:0] m_wdata,
  output logic [HW-1:0] h_rdata
);
  logic [AW-1:0] addr_q;
  logic          dm_q, half_q, pend_q, we_q;
  logic [HW-1:0] hi_q, rd_q;
  logic [OW-1:0] lo_q;
  logic [PW-1:0] wd_q;
  logic          grant, blocked;

  assign grant   = pend_q && m_gnt;
  assign blocked = (ev == EV_WR) && in_ctl(dm_q, addr_q, CTL_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; dm_q <= 1'b0; half_q <= 1'b0; pend_q <= 1'b0;
      we_q <= 1'b0; hi_q <= '0; rd_q <= '0; lo_q <= '0; wd_q <= '0;
    end else begin
      if (ld) begin
        addr_q <= ld_addr;
        dm_q   <= ld_dm;
        half_q <= 1'b0;
      end
      if (grant) begin
        pend_q <= 1'b0;
        addr_q <= addr_next(addr_q);
        if (!we_q) begin
          if (dm_q) rd_q <= m_rdata[HW-1:0];
          else begin
            rd_q   <= m_rdata[PW-1:PW-HW];
            lo_q   <= m_rdata[OW-1:0];
            half_q <= 1'b1;
          end
        end
      end
      case (ev)
        EV_WR: begin
          if (!dm_q) begin
            if (!half_q) begin
              hi_q   <= wdata;
              half_q <= 1'b1;
            end else begin
              wd_q   <= pm_join(hi_q, wdata);
              we_q   <= 1'b1;
              pend_q <= 1'b1;
              half_q <= 1'b0;
            end
          end else if (blocked) begin
            addr_q <= addr_next(addr_q);
          end else begin
            wd_q   <= {{(PW-HW){1'b0}}, wdata};
            we_q   <= 1'b1;
            pend_q <= 1'b1;
          end
        end
        EV_RD: begin
          if (!dm_q && half_q) begin
            rd_q   <= low_word(lo_q);
            half_q <= 1'b0;
          end else begin
            we_q   <= 1'b0;
            pend_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy    = pend_q;
  assign m_req   = pend_q;
  assign m_we    = we_q;
  assign m_space = dm_q;
  assign m_addr  = addr_q;
  assign m_wdata = wd_q;
  assign h_rdata = rd_q;

  // R8: request held steady until granted
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_wdata) && $stable(m_we)));
  // R8: one grant per request
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_gnt) |=> !m_req);
  // R7: address steps by one per granted word
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_gnt) |=> (m_addr == addr_next($past(m_addr))));
  // R9: no write request into the control range
  a_r9_no_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we && m_space) |-> (m_addr < CTL_BASE));
  // R10: dropped strobe leaves a waiting request untouched
  a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_wdata)));
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
  import hmp_pkg::*;
#(
  parameter logic [13:0] CTL_BASE = 14'h3FE0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_sel,
  input  logic        h_latch,
  input  logic        h_rd,
  input  logic        h_wr,
  input  logic [15:0] h_wdata,
  output logic [15:0] h_rdata,
  output logic        h_ack,
  output logic [7:0]  ovl_sel,
  output logic        cfg_err,
  output logic        m_req,
  input  logic        m_gnt,
  output logic        m_we,
  output logic        m_space,
  output logic [13:0] m_addr,
  output logic [23:0] m_wdata,
  input  logic [23:0] m_rdata
);
  hev_e          ev;
  logic          ev_drop, busy, ld, ld_dm;
  logic [AW-1:0] ld_addr;

  hmp_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .sel(h_sel), .lat(h_latch), .wr(h_wr), .rd(h_rd),
    .busy(busy), .ev(ev), .ev_drop(ev_drop)
  );

  hmp_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wdata(h_wdata), .ovl(ovl_sel), .err(cfg_err),
    .ld(ld), .ld_addr(ld_addr), .ld_dm(ld_dm)
  );

  hmp_xfer #(.CTL_BASE(CTL_BASE)) u_xfer (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ev_drop(ev_drop), .wdata(h_wdata),
    .ld(ld), .ld_addr(ld_addr), .ld_dm(ld_dm), .m_gnt(m_gnt), .m_rdata(m_rdata),
    .busy(busy), .m_req(m_req), .m_we(m_we), .m_space(m_space), .m_addr(m_addr),
    .m_wdata(m_wdata), .h_rdata(h_rdata)
  );

  assign h_ack = !busy;

  // R8: acknowledge returns right after the grant
  a_r8_ack_back: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_gnt) |=> h_ack);
endmodule

// File: tb/sim_hostmem_port.sv
module sim_hostmem_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_sel = 0, h_latch = 0, h_rd = 0, h_wr = 0;
  logic [15:0] h_wdata = '0, h_rdata;
  logic h_ack, cfg_err, m_req, m_gnt, m_we, m_space;
  logic [7:0] ovl_sel;
  logic [13:0] m_addr;
  logic [23:0] m_wdata, m_rdata;

  int total = 0, bad = 0;
  int gnt_delay = 0;
  logic gnt_en = 1'b1;
  logic [3:0] wcnt;
  int gcnt = 0;
  logic pre_we = 0, pre_dm = 0;
  logic [7:0] pre_idx = '0;
  logic [23:0] pre_val = '0;
  logic [23:0] pm_mem [256];
  logic [23:0] dm_mem [256];

  always #4 clk = ~clk;  // 125 MHz

  hostmem_port u0 (.*);

  assign m_gnt   = m_req && gnt_en && (int'(wcnt) >= gnt_delay);
  assign m_rdata = m_space ? dm_mem[m_addr[7:0]] : pm_mem[m_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) wcnt <= '0;
    else if (m_req && !m_gnt) wcnt <= wcnt + 4'd1;
    else wcnt <= '0;
    if (m_req && m_gnt) gcnt <= gcnt + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin pm_mem[i] <= '0; dm_mem[i] <= '0; end
    end else if (pre_we) begin
      if (pre_dm) dm_mem[pre_idx] <= pre_val; else pm_mem[pre_idx] <= pre_val;
    end else if (m_req && m_gnt && m_we) begin
      if (m_space) dm_mem[m_addr[7:0]] <= m_wdata; else pm_mem[m_addr[7:0]] <= m_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 latch, 1 write, 2 read
  task automatic hop(input int op, input logic [15:0] d);
    @(negedge clk);
    h_sel = 1; h_wdata = d;
    if (op == 0) h_latch = 1; else if (op == 1) h_wr = 1; else h_rd = 1;
    @(negedge clk);
    h_sel = 0; h_latch = 0; h_wr = 0; h_rd = 0;
    while (!h_ack) @(negedge clk);
  endtask

  task automatic preload(input logic dm, input logic [7:0] idx, input logic [23:0] v);
    @(negedge clk);
    pre_we = 1; pre_dm = dm; pre_idx = idx; pre_val = v;
    @(negedge clk);
    pre_we = 0;
  endtask

  // {tag[3:0], op[1:0], data[15:0], expected[15:0]}
  localparam logic [37:0] VEC [19] = '{
    {4'd2, 2'd0, 16'h4010, 16'h0000},  // R2 DM address 0x10
    {4'd5, 2'd1, 16'h1234, 16'h0000},  // R5
    {4'd5, 2'd1, 16'hBEEF, 16'h0000},  // R5
    {4'd2, 2'd0, 16'h4010, 16'h0000},  // R2
    {4'd5, 2'd2, 16'h0000, 16'h1234},  // R5 read back
    {4'd7, 2'd2, 16'h0000, 16'hBEEF},  // R7 next address
    {4'd2, 2'd0, 16'h0020, 16'h0000},  // R2 PM address 0x20
    {4'd6, 2'd1, 16'hA5C3, 16'h0000},  // R6 upper
    {4'd6, 2'd1, 16'h0077, 16'h0000},  // R6 low byte
    {4'd6, 2'd1, 16'h1111, 16'h0000},  // R6
    {4'd6, 2'd1, 16'hFF22, 16'h0000},  // R6 upper byte of second word dropped
    {4'd2, 2'd0, 16'h0020, 16'h0000},  // R2
    {4'd6, 2'd2, 16'h0000, 16'hA5C3},  // R6
    {4'd6, 2'd2, 16'h0000, 16'h0077},  // R6
    {4'd6, 2'd2, 16'h0000, 16'h1111},  // R6
    {4'd6, 2'd2, 16'h0000, 16'h0022},  // R6
    {4'd3, 2'd0, 16'h8005, 16'h0000},  // R3 overlay 5
    {4'd2, 2'd0, 16'h4011, 16'h0000},  // R2
    {4'd2, 2'd2, 16'h0000, 16'hBEEF}   // R2
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g0, lowcnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ack", 32'(h_ack), 1);
    chk("R1 req", 32'(m_req), 0);
    chk("R1 ovl", 32'(ovl_sel), 0);
    chk("R1 err", 32'(cfg_err), 0);
    chk("R1 rdata", 32'(h_rdata), 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 19; i++) begin
      gnt_delay = i % 3;
      hop(int'(VEC[i][33:32]), VEC[i][31:16]);
      if (VEC[i][33:32] == 2'd2)
        chk($sformatf("R%0d vec%0d", VEC[i][37:34], i), 32'(h_rdata), 32'(VEC[i][15:0]));
    end
    gnt_delay = 0;
    chk("R3 overlay", 32'(ovl_sel), 32'h05);
    chk("R6 packed", 32'(pm_mem[8'h20]), 32'hA5C377);
    chk("R5 dm pad", 32'(dm_mem[8'h11]), 32'h00BEEF);

    // R4 malformed overlay word
    hop(0, 16'h8105);
    chk("R4 err", 32'(cfg_err), 1);
    chk("R4 ovl kept", 32'(ovl_sel), 32'h05);
    hop(0, 16'h80AA);
    chk("R3 err clear", 32'(cfg_err), 0);
    chk("R3 ovl AA", 32'(ovl_sel), 32'hAA);

    // R3 overlay does not move address
    hop(0, 16'h4010);
    hop(0, 16'h8003);
    hop(2, 16'h0);
    chk("R3 addr kept", 32'(h_rdata), 32'h1234);

    // R8 acknowledge window with grant delay 2
    hop(0, 16'h4040);
    gnt_delay = 2;
    g0 = gcnt;
    @(negedge clk); h_sel = 1; h_wdata = 16'h7777; h_wr = 1;
    @(negedge clk); h_sel = 0; h_wr = 0;
    chk("R8 req up", 32'(m_req), 1);
    lowcnt = 0;
    while (!h_ack && lowcnt < 20) begin lowcnt++; @(negedge clk); end
    chk("R8 ack low cycles", lowcnt, 3);
    chk("R8 one grant", gcnt - g0, 1);
    chk("R8 data", 32'(dm_mem[8'h40]), 32'h007777);
    gnt_delay = 0;

    // R9 write into control range blocked
    preload(1, 8'hE5, 24'h00CAFE);
    preload(1, 8'hE6, 24'h00D00D);
    hop(0, 16'h7FE5);
    g0 = gcnt;
    @(negedge clk); h_sel = 1; h_wdata = 16'h1111; h_wr = 1;
    @(negedge clk); h_sel = 0; h_wr = 0;
    chk("R9 ack stays", 32'(h_ack), 1);
    @(negedge clk);
    chk("R9 no request", gcnt - g0, 0);
    hop(2, 16'h0);
    chk("R9 addr advanced", 32'(h_rdata), 32'hD00D);
    hop(0, 16'h7FE5);
    hop(2, 16'h0);
    chk("R9 content kept", 32'(h_rdata), 32'hCAFE);

    // R10 strobe while pending
    hop(0, 16'h4030);
    gnt_en = 0;
    g0 = gcnt;
    @(negedge clk); h_sel = 1; h_wdata = 16'h5555; h_wr = 1;
    @(negedge clk); h_sel = 0; h_wr = 0;
    @(negedge clk); h_sel = 1; h_wdata = 16'h6666; h_wr = 1;
    @(negedge clk); h_sel = 0; h_wr = 0;
    @(negedge clk); gnt_en = 1;
    while (!h_ack) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R10 first kept", 32'(dm_mem[8'h30]), 32'h005555);
    chk("R10 second ignored", 32'(dm_mem[8'h31]), 32'h0);
    chk("R10 one grant", gcnt - g0, 1);

    // R11 strobe without select
    g0 = gcnt;
    @(negedge clk); h_rd = 1; h_wr = 1;
    @(negedge clk); h_rd = 0; h_wr = 0;
    @(negedge clk);
    chk("R11 no request", gcnt - g0, 0);
    chk("R11 ack", 32'(h_ack), 1);
    chk("R11 rdata", 32'(h_rdata), 32'hCAFE);

    // R7 wrap at top of program memory
    hop(0, 16'h3FFF);
    hop(1, 16'h1357);
    hop(1, 16'h0024);
    hop(1, 16'h2468);
    hop(1, 16'h0099);
    @(negedge clk);
    chk("R7 last word", 32'(pm_mem[8'hFF]), 32'h135724);
    chk("R7 wrapped word", 32'(pm_mem[8'h00]), 32'h246899);
    chk("R7 wrapped addr", 32'(m_addr), 32'h0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule